// File: doc/BRIEF.md
# Asymmetric Decoder Slot Steering

This block sits between an instruction queue and a row of four decode slots. Every cycle it looks at a window of up to four entries at the head of the queue. Each entry carries only its micro-operation count. The block forms an in-order issue group and places entry k in slot k. Slot 0 is the only wide slot. The other slots take single micro-operation instructions only, with a fused pair counted as one.

An entry that needs more micro-operations than the wide slot can produce is handed to a microcode sequencer. The sequencer is modelled as a counter of micro-operations still to be emitted. It emits at most four per cycle, and the normal slots stay empty until it has emitted its last one. A downstream ready input gates all progress. The block tells the queue how many entries it consumed in each cycle.

Control is a two-state machine. STEER forms groups from the window. SEQ drains the sequencer. The transition STEER→SEQ ("handoff") is taken when the head entry is long and downstream is ready. The transition SEQ→STEER ("drain done") is taken when the final sequencer beat is accepted. Otherwise each state holds: STEER when no handoff occurs, SEQ while micro-operations remain or downstream is stalled.

Top module: `dss_steer`

## Requirements
- R1: While reset is asserted, and right after it, the block is in STEER. `ms_busy` is low and no handoff takes place, even when the head entry is long.
- R2: In STEER, slot 0 is filled when the head entry is valid (`q_avail` ≥ 1) and its count lies in 1..4. Slot 0 then carries that count and window index 0.
- R3: Slot k (k = 1..3) is filled only when slots 0..k-1 are filled, entry k is valid (k < `q_avail`), and entry k's count is exactly 1. Filled slot k carries count 1 and index k. The first entry that fails these conditions ends the group. Unfilled slots show valid 0, count 0 and index 0.
- R4: A head entry with a count above 4 fills no slot. While `dn_ready` is high it raises `ms_start` for one cycle and consumes exactly that one entry. A long entry at window position 1..3 ends the group and is not consumed.
- R5: After a handoff of count N, `ms_busy` is high for ceil(N/4) accepted cycles. The `ms_uops` value is 4 in each of those cycles except the last, which carries the remainder (N − 4·(ceil(N/4) − 1)).
- R6: While `ms_busy` is high, no slot is valid and nothing is consumed. Steering resumes in the cycle after the last sequencer beat is accepted.
- R7: With `dn_ready` low, `consumed` is 0 and no handoff occurs. In STEER the slot outputs still show the group formed from the window. In SEQ, `ms_uops` and the remaining count stay unchanged.
- R8: In STEER with `dn_ready` high, `consumed` equals the number of filled slots, or 1 on a handoff.
- Entry counts are at least 1. Window entry k occupies bits [k*5 +: 5] of `q_uops`. Slot k occupies bits [k*5 +: 5] of `slot_uops` and bits [k*2 +: 2] of `slot_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_avail | input | 3 | Number of valid entries at the queue head (0..4) |
| q_uops | input | 20 | Micro-operation count of each window entry, 5 bits each |
| dn_ready | input | 1 | Downstream accepts this cycle's output |
| slot_valid | output | 4 | Per-slot valid |
| slot_idx | output | 8 | Window index placed in each slot, 2 bits each |
| slot_uops | output | 20 | Micro-operation count in each slot, 5 bits each |
| consumed | output | 3 | Queue entries consumed this cycle |
| ms_start | output | 1 | Handoff of the head entry to the sequencer |
| ms_busy | output | 1 | Sequencer is emitting micro-operations |
| ms_uops | output | 3 | Micro-operations the sequencer emits this cycle |

## Verification
A wrong state bit appears at once as an empty group, or as `ms_busy` with the wrong polarity, in the same cycle as the window that exposes it. A wrong remaining count shows up as an incorrect `ms_uops` beat. It also shows up as a sequencer run one cycle too long or too short, which is visible no later than the cycle after the expected last beat, when steering should already have resumed. Errors in the grouping rule show directly on `slot_valid` and `consumed` for the window that triggers them, because the steering outputs are combinational from the window and the state.

// File: rtl/dss_pkg.sv
package dss_pkg;
    typedef enum logic [0:0] {
        ST_STEER = 1'b0,
        ST_SEQ   = 1'b1
    } dss_state_e;
endpackage

// File: rtl/dss_slot_pick.sv
module dss_slot_pick #(
    parameter int NSLOT   = 4,
    parameter int CW      = 5,
    parameter int CPX_MAX = 4,
    parameter int AW      = $clog2(NSLOT + 1)
) (
    input  logic [AW-1:0]       avail,
    input  logic [NSLOT*CW-1:0] uops,
    output logic [NSLOT-1:0]    take,
    output logic                head_long,
    output logic [AW-1:0]       ntake
);
    logic [NSLOT-1:0] fits;

    for (genvar k = 0; k < NSLOT; k++) begin : g_fit
        logic [CW-1:0] cnt;
        logic          present;
        assign cnt     = uops[k*CW +: CW];
        assign present = AW'(k) < avail;
        if (k == 0) begin : g_wide
            assign fits[k] = present && (cnt >= CW'(1)) && (cnt <= CW'(CPX_MAX));
        end else begin : g_narrow
            assign fits[k] = present && (cnt == CW'(1));
        end
    end

    always_comb begin
        take[0] = fits[0];
        for (int k = 1; k < NSLOT; k++) begin
            take[k] = take[k-1] && fits[k];
        end
    end

    always_comb begin
        ntake = '0;
        for (int k = 0; k < NSLOT; k++) begin
            ntake = ntake + AW'(take[k]);
        end
    end

    assign head_long = (avail != '0) && (uops[CW-1:0] > CW'(CPX_MAX));
endmodule

// File: rtl/dss_useq.sv
module dss_useq #(
    parameter int CW      = 5,
    parameter int MS_RATE = 4,
    parameter int RW      = $clog2(MS_RATE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic [RW-1:0] emit,
    output logic          last
);
    logic [CW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (step) begin
            rem_q <= rem_q - CW'(emit);
        end
    end

    assign emit = (rem_q > CW'(MS_RATE)) ? RW'(MS_RATE) : RW'(rem_q);
    assign last = (rem_q <= CW'(MS_RATE));

    // R5: a stepped beat never exceeds the rate and is never empty
    assert_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (emit != '0) && (emit <= RW'(MS_RATE)));
endmodule

// File: rtl/dss_steer.sv
module dss_steer #(
    parameter int NSLOT   = 4,
    parameter int CW      = 5,
    parameter int CPX_MAX = 4,
    parameter int MS_RATE = 4,
    parameter int AW      = $clog2(NSLOT + 1),
    parameter int IW      = $clog2(NSLOT),
    parameter int RW      = $clog2(MS_RATE + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       q_avail,
    input  logic [NSLOT*CW-1:0] q_uops,
    input  logic                dn_ready,
    output logic [NSLOT-1:0]    slot_valid,
    output logic [NSLOT*IW-1:0] slot_idx,
    output logic [NSLOT*CW-1:0] slot_uops,
    output logic [AW-1:0]       consumed,
    output logic                ms_start,
    output logic                ms_busy,
    output logic [RW-1:0]       ms_uops
);
    import dss_pkg::*;

    dss_state_e       state_q, state_d;
    logic [NSLOT-1:0] take;
    logic             head_long;
    logic [AW-1:0]    ntake;
    logic [RW-1:0]    seq_emit;
    logic             seq_last;
    logic             seq_step;

    dss_slot_pick #(
        .NSLOT(NSLOT), .CW(CW), .CPX_MAX(CPX_MAX), .AW(AW)
    ) u_pick (
        .avail(q_avail), .uops(q_uops),
        .take(take), .head_long(head_long), .ntake(ntake)
    );

    assign seq_step = (state_q == ST_SEQ) && dn_ready;

    dss_useq #(
        .CW(CW), .MS_RATE(MS_RATE), .RW(RW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load(ms_start), .load_val(q_uops[CW-1:0]),
        .step(seq_step), .emit(seq_emit), .last(seq_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STEER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEER: if (dn_ready && head_long) state_d = ST_SEQ;
            ST_SEQ:   if (dn_ready && seq_last)  state_d = ST_STEER;
            default:  state_d = ST_STEER;
        endcase
    end

    always_comb begin
        slot_valid = '0;
        consumed   = '0;
        ms_start   = 1'b0;
        ms_busy    = 1'b0;
        ms_uops    = '0;
        unique case (state_q)
            ST_STEER: begin
                slot_valid = take;
                ms_start   = rst_n && dn_ready && head_long;
                if (dn_ready) consumed = head_long ? AW'(1) : ntake;
            end
            ST_SEQ: begin
                ms_busy = 1'b1;
                ms_uops = seq_emit;
            end
            default: ;
        endcase
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot_uops[k*CW +: CW] = slot_valid[k] ? q_uops[k*CW +: CW] : '0;
        assign slot_idx[k*IW +: IW]  = slot_valid[k] ? IW'(k) : '0;
        if (k == 0) begin : g_a0
            // R2: wide slot holds one to CPX_MAX micro-operations
            assert_slot0_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[0] |-> (slot_uops[CW-1:0] >= CW'(1)) &&
                                  (slot_uops[CW-1:0] <= CW'(CPX_MAX)));
        end else begin : g_an
            // R3: narrow slots hold single micro-operations, in order
            assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k] |-> (slot_uops[k*CW +: CW] == CW'(1)));
            assert_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[k] |-> slot_valid[k-1]);
        end
    end

    // R6: no slot issues while the sequencer runs
    assert_idle_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ms_busy |-> (slot_valid == '0) && (consumed == '0));
    // R7: a stalled sequencer beat stays unchanged
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_busy && !dn_ready) |=> (ms_busy && $stable(ms_uops)));
    // R4: a handoff consumes exactly one entry and enters the sequencer
    assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ms_start |-> (consumed == AW'(1)) && (slot_valid == '0));
    assert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ms_start |=> ms_busy);
    // R8: consumption never exceeds the window
    assert_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        consumed <= q_avail);
endmodule

// File: tb/dss_steer_tb.sv
module dss_steer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  q_avail = '0;
    logic [19:0] q_uops = '0;
    logic        dn_ready = 1'b0;
    logic [3:0]  slot_valid;
    logic [7:0]  slot_idx;
    logic [19:0] slot_uops;
    logic [2:0]  consumed;
    logic        ms_start;
    logic        ms_busy;
    logic [2:0]  ms_uops;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dss_steer u_dut (
        .clk(clk), .rst_n(rst_n), .q_avail(q_avail), .q_uops(q_uops),
        .dn_ready(dn_ready), .slot_valid(slot_valid), .slot_idx(slot_idx),
        .slot_uops(slot_uops), .consumed(consumed), .ms_start(ms_start),
        .ms_busy(ms_busy), .ms_uops(ms_uops)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_win(input int avail, input int u0, input int u1, input int u2, input int u3);
        q_avail = 3'(avail);
        q_uops  = {5'(u3), 5'(u2), 5'(u1), 5'(u0)};
    endtask

    // Expected STEER outputs for the current window; returns handoff
    task automatic chk_steer(input string req, input bit rdy, output bit hand);
        int u[4];
        int ev, eidx, euops, n;
        bit go;
        for (int k = 0; k < 4; k++) u[k] = int'(q_uops[k*5 +: 5]);
        ev = 0; eidx = 0; euops = 0; n = 0; go = 1;
        for (int k = 0; k < 4; k++) begin
            bit ok;
            ok = (k < int'(q_avail)) && ((k == 0) ? (u[k] >= 1 && u[k] <= 4) : (u[k] == 1));
            go = go && ok;
            if (go) begin
                ev |= (1 << k);
                eidx |= (k << (2*k));
                euops |= (u[k] << (5*k));
                n++;
            end
        end
        hand = rdy && (q_avail != 0) && (u[0] > 4);
        chk(req, "slot_valid", int'(slot_valid), ev);
        chk(req, "slot_idx", int'(slot_idx), eidx);
        chk(req, "slot_uops", int'(slot_uops), euops);
        chk("R8", "consumed", int'(consumed), rdy ? (hand ? 1 : n) : 0);
        chk("R4", "ms_start", int'(ms_start), int'(hand));
        chk("R6", "ms_busy", int'(ms_busy), 0);
    endtask

    task automatic drain(input int n);
        int rem = n;
        while (rem > 0) begin
            int e = (rem > 4) ? 4 : rem;
            @(negedge clk); #1;
            chk("R5", "ms_busy", int'(ms_busy), 1);
            chk("R5", "ms_uops", int'(ms_uops), e);
            chk("R6", "slot_valid", int'(slot_valid), 0);
            chk("R6", "consumed", int'(consumed), 0);
            rem -= e;
        end
    endtask

    initial begin
        bit hand;
        int vals[5] = '{1, 2, 4, 5, 9};
        // R1: reset holds STEER even with a long head
        dn_ready = 1'b1;
        set_win(4, 9, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R1", "ms_busy in reset", int'(ms_busy), 0);
        chk("R1", "ms_start in reset", int'(ms_start), 0);
        set_win(0, 1, 1, 1, 1);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1", "ms_busy after reset", int'(ms_busy), 0);
        chk_steer("R1", 1'b1, hand);

        // R2 R3 R4 R5 R6 R8: sweep windows
        for (int a = 0; a <= 4; a++)
            for (int i0 = 0; i0 < 5; i0++)
                for (int i1 = 0; i1 < 5; i1++)
                    for (int i2 = 0; i2 < 5; i2++)
                        for (int i3 = 0; i3 < 5; i3++) begin
                            @(negedge clk);
                            set_win(a, vals[i0], vals[i1], vals[i2], vals[i3]);
                            #1;
                            chk_steer("R3", 1'b1, hand);
                            if (hand) drain(vals[i0]);
                        end

        // R7: stall in STEER with a full single group
        @(negedge clk); dn_ready = 1'b0; set_win(4, 2, 1, 1, 1); #1;
        chk_steer("R7", 1'b0, hand);
        // R7: stalled long head causes no handoff
        @(negedge clk); set_win(4, 9, 1, 1, 1); #1;
        chk_steer("R7", 1'b0, hand);
        @(negedge clk); #1;
        chk("R7", "no handoff while stalled", int'(ms_busy), 0);
        // R7: stall inside the sequencer keeps its beat
        dn_ready = 1'b1; #1;
        chk("R4", "ms_start", int'(ms_start), 1);
        @(negedge clk); dn_ready = 1'b0; set_win(0, 1, 1, 1, 1); #1;
        for (int s = 0; s < 3; s++) begin
            chk("R7", "held busy", int'(ms_busy), 1);
            chk("R7", "held beat", int'(ms_uops), 4);
            chk("R7", "held consumed", int'(consumed), 0);
            @(negedge clk); #1;
        end
        dn_ready = 1'b1; #1;
        chk("R5", "beat 1", int'(ms_uops), 4);
        @(negedge clk); dn_ready = 1'b0; #1;
        chk("R5", "beat 2", int'(ms_uops), 4);
        @(negedge clk); #1;
        chk("R7", "held beat 2", int'(ms_uops), 4);
        dn_ready = 1'b1;
        @(negedge clk); #1;
        chk("R5", "last beat", int'(ms_uops), 1);
        @(negedge clk); set_win(4, 1, 1, 1, 1); #1;
        chk("R6", "resumed", int'(ms_busy), 0);
        chk_steer("R6", 1'b1, hand);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule